// File: doc/BRIEF.md
# Multi-Pattern Test Data Generator

This block produces one parallel transmit word on every clock for link loopback testing. A three-bit mode input picks the pattern. Four modes are pseudo-random bit sequences of order 7, 15, 23 and 31. One mode is a fixed toggle pattern at half the line rate. One mode is a slow square wave at one thirty-third of the line rate. Each word holds 32 consecutive line bits, and bit 0 is the first bit sent.

A run-enable input gates the stream. A one-cycle inject pulse flips one bit in exactly one outgoing word, so the receiving checker sees a known error. A counter records how many injections were accepted, and a clear pulse zeroes that counter. The output word and the counter are both registered.

Top module: `tpg_top`

## Requirements
- R1: While reset is high and on the first edge after it, `tx_word` is 0 and `inj_count` is 0. Reset selects mode code 0 (PRBS7), loads all ones into every sequence register, and sets the square-wave phase to the start of its high run.
- R2: Mode codes are: 0 = PRBS7 (x^7+x^6+1), 1 = PRBS15 (x^15+x^14+1), 2 = PRBS23 (x^23+x^18+1), 3 = PRBS31 (x^31+x^28+1), 4 = half-rate toggle, 5 = square wave. Codes 6 and 7 produce the PRBS7 stream.
- R3: In a sequence mode of order N with inner tap T, each new line bit is the XOR of the bits emitted N and T positions earlier. Before the first bit, the history is all ones. Word bit i is the i-th bit of the word, 32 bits per clock, and bit 0 comes first.
- R4: In mode 4, every word is 32'h5555_5555, so bit 0 is 1.
- R5: In mode 5, the line carries 17 ones followed by 16 zeros, repeating. The phase continues across word boundaries.
- R6: On an edge where `run_en` is low, the next `tx_word` is 0 and no generator advances. When enable returns, the stream resumes where it stopped.
- R7: On an edge where `mode_sel` differs from the registered mode, the new mode is registered, every generator is reseeded as in R1, `tx_word` becomes 0 and an inject request is ignored. The next enabled word starts from the seed.
- R8: An inject request is accepted on an edge with `run_en` high and no mode change. It inverts bit 0 of the word issued at that edge only, and the sequence itself is not disturbed.
- R9: Each accepted injection adds one to `inj_count`.
- R10: An inject request that is not accepted leaves `inj_count` unchanged, and `tx_word` stays 0.
- R11: `cnt_clr` sets `inj_count` to 0 on the next edge. If an accepted injection falls on the same edge, the result is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Pattern select (R2 codes) |
| run_en | input | 1 | Test running; gates output and advance |
| inj_req | input | 1 | One-cycle error inject request |
| cnt_clr | input | 1 | Zero the injection counter |
| tx_word | output | 32 | Registered data word, bit 0 sent first |
| inj_count | output | 16 | Accepted injection count |

## Verification
The PRBS7 run lasts long enough to pass its 127-bit period several times, so a wrong tap or a reversed bit order makes the first word after the seed diverge. The square-wave run crosses many word boundaries, which catches a design that restarts the pattern on every word. The bench pauses the enable mid-stream and expects the stream to resume where it stopped; a design that keeps advancing, or reseeds, would emit the wrong words. Inject pulses are placed while disabled, on a mode-change edge and together with a clear; a design that counts ignored requests, or lets clear lose to injection, shows a wrong count.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int MODE_W = 3;
  localparam int NUM_PRBS = 4;
  localparam int LF_PERIOD = 33;
  localparam int LF_HIGH = 17;

  typedef enum logic [MODE_W-1:0] {
    MODE_P7  = 3'd0,
    MODE_P15 = 3'd1,
    MODE_P23 = 3'd2,
    MODE_P31 = 3'd3,
    MODE_HF  = 3'd4,
    MODE_LF  = 3'd5
  } mode_e;

  function automatic int prbs_order(input int idx);
    case (idx)
      0: return 7;
      1: return 15;
      2: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int prbs_tap(input int idx);
    case (idx)
      0: return 6;
      1: return 14;
      2: return 18;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/tpg_prbs.sv
module tpg_prbs #(
  parameter int ORDER = 7,
  parameter int TAP = 6,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reseed,
  input  logic         adv,
  output logic [W-1:0] word
);
  logic [ORDER-1:0] state_q;
  logic [ORDER-1:0] state_nxt;

  always_comb begin
    logic [ORDER-1:0] s;
    logic b;
    s = state_q;
    word = '0;
    for (int i = 0; i < W; i++) begin
      b = s[ORDER-1] ^ s[TAP-1];
      word[i] = b;
      s = {s[ORDER-2:0], b};
    end
    state_nxt = s;
  end

  always_ff @(posedge clk) begin
    if (rst || reseed) state_q <= '1;
    else if (adv)      state_q <= state_nxt;
  end

  // R6: a stalled generator keeps its state
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!reseed && !adv) |=> $stable(state_q));
endmodule

// File: rtl/tpg_lowfreq.sv
module tpg_lowfreq #(
  parameter int W = 32,
  parameter int PERIOD = 33,
  parameter int HIGH = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reseed,
  input  logic         adv,
  output logic [W-1:0] word
);
  localparam int PH_W = $clog2(PERIOD);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_nxt;

  always_comb begin
    logic [PH_W-1:0] p;
    p = phase_q;
    word = '0;
    for (int i = 0; i < W; i++) begin
      word[i] = (int'(p) < HIGH);
      p = (int'(p) == PERIOD - 1) ? '0 : p + 1'b1;
    end
    phase_nxt = p;
  end

  always_ff @(posedge clk) begin
    if (rst || reseed) phase_q <= '0;
    else if (adv)      phase_q <= phase_nxt;
  end

  // R5: the phase stays inside one period
  assert_phase_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    int'(phase_q) < PERIOD);
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_sel,
  input  logic              run_en,
  input  logic              inj_req,
  input  logic              cnt_clr,
  output logic [DATA_W-1:0] tx_word,
  output logic [CNT_W-1:0]  inj_count
);
  logic [MODE_W-1:0] mode_q;
  logic              mode_chg;
  logic              advance;
  logic              inj_ok;
  logic [DATA_W-1:0] prbs_w [NUM_PRBS];
  logic [DATA_W-1:0] lf_w;
  logic [DATA_W-1:0] hf_w;
  logic [DATA_W-1:0] sel_w;

  assign mode_chg = (mode_sel != mode_q);
  assign advance  = run_en && !mode_chg;
  assign inj_ok   = advance && inj_req;

  for (genvar g = 0; g < NUM_PRBS; g++) begin : g_prbs
    tpg_prbs #(
      .ORDER(prbs_order(g)),
      .TAP(prbs_tap(g)),
      .W(DATA_W)
    ) prbs_i (
      .clk(clk),
      .rst(rst),
      .reseed(mode_chg),
      .adv(advance),
      .word(prbs_w[g])
    );
  end

  tpg_lowfreq #(
    .W(DATA_W),
    .PERIOD(LF_PERIOD),
    .HIGH(LF_HIGH)
  ) lf_i (
    .clk(clk),
    .rst(rst),
    .reseed(mode_chg),
    .adv(advance),
    .word(lf_w)
  );

  always_comb begin
    for (int i = 0; i < DATA_W; i++) hf_w[i] = ((i % 2) == 0);
  end

  always_comb begin
    case (mode_q)
      MODE_P7:  sel_w = prbs_w[0];
      MODE_P15: sel_w = prbs_w[1];
      MODE_P23: sel_w = prbs_w[2];
      MODE_P31: sel_w = prbs_w[3];
      MODE_HF:  sel_w = hf_w;
      MODE_LF:  sel_w = lf_w;
      default:  sel_w = prbs_w[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_P7;
      tx_word   <= '0;
      inj_count <= '0;
    end else begin
      if (mode_chg) mode_q <= mode_sel;
      tx_word <= advance ? (sel_w ^ {{(DATA_W-1){1'b0}}, inj_ok}) : '0;
      if (cnt_clr)     inj_count <= {{(CNT_W-1){1'b0}}, inj_ok};
      else if (inj_ok) inj_count <= inj_count + 1'b1;
    end
  end

  // R6: disabled edge yields a zero word
  assert_idle_word_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> tx_word == '0);
  // R7: mode change edge yields a zero word
  assert_mode_change_zero_R7: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> tx_word == '0);
  // R11: clear leaves at most the same-edge injection
  assert_clear_result_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> inj_count <= CNT_W'(1));
  // R10: no accepted injection and no clear keeps the count
  assert_count_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!inj_ok && !cnt_clr) |=> $stable(inj_count));
  // R9: accepted injection adds one
  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    (inj_ok && !cnt_clr) |=> inj_count == $past(inj_count) + CNT_W'(1));
  // R4: clean toggle word in half-rate mode
  assert_hf_word_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && !inj_req && mode_q == MODE_HF) |=> tx_word == {(DATA_W/2){2'b01}});
endmodule

// File: tb/tpg_top_tb_top.sv
module tpg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_sel = 3'd0;
  logic        run_en = 1'b0;
  logic        inj_req = 1'b0;
  logic        cnt_clr = 1'b0;
  logic [31:0] tx_word;
  logic [15:0] inj_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] word;
    logic [15:0] cnt;
    string tag;
  } exp_t;
  exp_t sb[$];

  // model state
  logic [2:0]  m_mode;
  logic [63:0] hist [4];
  int          lf_pos;
  logic [15:0] m_cnt;

  always #5 clk = ~clk;

  tpg_top dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .run_en(run_en),
    .inj_req(inj_req), .cnt_clr(cnt_clr), .tx_word(tx_word), .inj_count(inj_count)
  );

  function automatic int ord_of(input int k);
    return (k == 0) ? 7 : (k == 1) ? 15 : (k == 2) ? 23 : 31;
  endfunction
  function automatic int tap_of(input int k);
    return (k == 0) ? 6 : (k == 1) ? 14 : (k == 2) ? 18 : 28;
  endfunction

  task automatic model_seed();
    for (int k = 0; k < 4; k++) hist[k] = '1;
    lf_pos = 0;
  endtask

  // Produce the next 32 line bits for every pattern; return the selected one.
  task automatic model_word(output logic [31:0] w);
    logic [31:0] pw [4];
    logic [31:0] lw;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 32; i++) begin
        logic nb;
        nb = hist[k][ord_of(k)-1] ^ hist[k][tap_of(k)-1];
        pw[k][i] = nb;
        hist[k] = {hist[k][62:0], nb};
      end
    end
    for (int i = 0; i < 32; i++) begin
      lw[i] = (lf_pos < 17);
      lf_pos = (lf_pos + 1) % 33;
    end
    case (m_mode)
      3'd1: w = pw[1];
      3'd2: w = pw[2];
      3'd3: w = pw[3];
      3'd4: w = 32'h5555_5555;
      3'd5: w = lw;
      default: w = pw[0];
    endcase
  endtask

  // Driver: apply one cycle of inputs and push the expected result.
  task automatic step(input logic [2:0] md, input logic en, input logic inj,
                      input logic clr, input string tag);
    exp_t e;
    logic [31:0] w;
    @(negedge clk);
    mode_sel = md; run_en = en; inj_req = inj; cnt_clr = clr;
    if (md != m_mode) begin
      m_mode = md;
      model_seed();
      w = '0;
      if (clr) m_cnt = '0;
    end else if (en) begin
      model_word(w);
      if (inj) w[0] = ~w[0];
      if (clr) m_cnt = '0;
      if (inj) m_cnt = m_cnt + 16'd1;
    end else begin
      w = '0;
      if (clr) m_cnt = '0;
    end
    e.word = w; e.cnt = m_cnt; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare each result shortly after the edge that produced it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (tx_word !== e.word || inj_count !== e.cnt) begin
          errors++;
          $display("FAIL %s: word %h cnt %0d, expected word %h cnt %0d",
                   e.tag, tx_word, inj_count, e.word, e.cnt);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_mode = 3'd0; m_cnt = '0; model_seed();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    checks++;
    if (tx_word !== 32'd0 || inj_count !== 16'd0) begin
      errors++;
      $display("FAIL R1: word %h cnt %0d, expected word 0 cnt 0", tx_word, inj_count);
    end
    // R1 R3: PRBS7 from seed, long enough to wrap its period
    for (int n = 0; n < 20; n++) step(3'd0, 1'b1, 1'b0, 1'b0, "R3 prbs7");
    // R8 R9: injections in the stream
    step(3'd0, 1'b1, 1'b1, 1'b0, "R8 inject");
    step(3'd0, 1'b1, 1'b0, 1'b0, "R8 next word clean");
    step(3'd0, 1'b1, 1'b1, 1'b0, "R9 second inject");
    // R6 R10: pause with an inject request, then resume
    step(3'd0, 1'b0, 1'b0, 1'b0, "R6 idle");
    step(3'd0, 1'b0, 1'b1, 1'b0, "R10 inject while idle");
    step(3'd0, 1'b0, 1'b0, 1'b0, "R6 idle");
    for (int n = 0; n < 4; n++) step(3'd0, 1'b1, 1'b0, 1'b0, "R6 resume");
    // R2 R7: other sequence orders, inject on the change edge ignored
    step(3'd1, 1'b1, 1'b1, 1'b0, "R7 change edge");
    for (int n = 0; n < 12; n++) step(3'd1, 1'b1, 1'b0, 1'b0, "R2 prbs15");
    step(3'd2, 1'b1, 1'b0, 1'b0, "R7 change edge");
    for (int n = 0; n < 12; n++) step(3'd2, 1'b1, 1'b0, 1'b0, "R2 prbs23");
    step(3'd3, 1'b0, 1'b0, 1'b0, "R7 change while idle");
    for (int n = 0; n < 12; n++) step(3'd3, 1'b1, 1'b0, 1'b0, "R2 prbs31");
    // R4: half-rate toggle with an injection
    step(3'd4, 1'b1, 1'b0, 1'b0, "R7 change edge");
    for (int n = 0; n < 4; n++) step(3'd4, 1'b1, 1'b0, 1'b0, "R4 toggle");
    step(3'd4, 1'b1, 1'b1, 1'b0, "R4 toggle inject");
    // R5: square wave across many words
    step(3'd5, 1'b1, 1'b0, 1'b0, "R7 change edge");
    for (int n = 0; n < 40; n++) step(3'd5, 1'b1, 1'b0, 1'b0, "R5 square");
    // R11: clear alone, then clear with injection
    step(3'd5, 1'b1, 1'b0, 1'b1, "R11 clear");
    step(3'd5, 1'b1, 1'b1, 1'b0, "R9 inject after clear");
    step(3'd5, 1'b1, 1'b1, 1'b1, "R11 clear with inject");
    step(3'd5, 1'b0, 1'b0, 1'b1, "R11 clear while idle");
    // R2: unused code acts as PRBS7
    step(3'd6, 1'b1, 1'b0, 1'b0, "R7 change edge");
    for (int n = 0; n < 6; n++) step(3'd6, 1'b1, 1'b0, 1'b0, "R2 code 6");
    step(3'd6, 1'b0, 1'b0, 1'b0, "R6 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule